// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access Check

This block keeps recently used page translations so that most memory accesses need no page table read. Each slot holds a virtual page number, the context ID of the application that owns it, the physical page number, and three permission bits for read, write and fetch. A lookup compares the incoming page number and context against every slot at once. Hit, miss, the physical page, the full physical address and a permission fault all come out combinationally in the same cycle.

After a miss, the page walker outside this block writes the translation in through the fill port. A fill whose page table valid flag is clear is dropped. This is because a slot's own valid bit only says that the slot holds a copy of a page table entry. Software can clear every slot in one cycle, or only the slots owned by one context, for example when an application ends. Page table walking and interrupt raising stay outside the block.

Top module: `xlate_cache`

## Requirements
- R1: A lookup hits in the same cycle when a valid slot holds both `lk_vpn` and `lk_ctx`. It then returns that slot's PPN on `lk_ppn`. With no such slot, `lk_miss` is 1, `lk_hit` is 0, and `lk_ppn` and `lk_paddr` are 0.
- R2: On a hit, `lk_paddr` equals {`lk_ppn`, `lk_ofs`}, with the offset passed through unchanged.
- R3: The permission bits are bit0 read, bit1 write and bit2 fetch. The access kind is coded 0 read, 1 write, 2 fetch, and 3 is never allowed. `lk_fault` is 1 on a hit whose permission bit for the access kind is clear. It is 0 on every miss.
- R4: Slots with the same VPN under different contexts coexist, and each context sees only its own translation.
- R5: A fill with `fl_pte_ok` = 0 changes nothing.
- R6: An accepted fill for a new VPN and context goes into the lowest-numbered invalid slot.
- R7: When every slot is valid, a new fill replaces the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and moves up by one, wrapping at the last slot, only when it is used.
- R8: A fill whose VPN and context already sit in a valid slot overwrites that slot and evicts nothing else.
- R9: `iv_all` clears every slot at the next clock edge.
- R10: `iv_ctx_en` clears, at the next clock edge, exactly the slots whose context equals `iv_ctx`.
- R11: When an invalidate and a fill arrive in the same cycle, the fill is dropped.
- R12: After reset every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_ofs | input | OFS_W | Page offset of the access |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| lk_ctx | input | CTX_W | Context of the running application |
| lk_hit | output | 1 | Matching slot found |
| lk_miss | output | 1 | No matching slot |
| lk_ppn | output | PPN_W | Cached physical page number |
| lk_paddr | output | PPN_W+OFS_W | Physical address |
| lk_fault | output | 1 | Hit but the access kind is not permitted |
| fl_en | input | 1 | Fill request |
| fl_vpn | input | VPN_W | Fill virtual page number |
| fl_ctx | input | CTX_W | Fill context |
| fl_ppn | input | PPN_W | Fill physical page number |
| fl_perm | input | 3 | Fill permissions {fetch, write, read} |
| fl_pte_ok | input | 1 | Page table entry valid flag |
| iv_all | input | 1 | Clear all slots |
| iv_ctx_en | input | 1 | Clear the slots of one context |
| iv_ctx | input | CTX_W | Context to clear |

## Verification
The hardest cases to reach from the ports are victim choice and placement in a free hole. A slot index never appears on an output. The bench fills a four-slot configuration completely, then opens a hole in slot 1 with a context flush. It then reads placement and pointer order only from which translations still hit after each later fill. The permission check is swept over all eight permission codes and all four access kinds by refilling one key. That refill also shows that updating a key in place evicts none of its neighbours.

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFS_W   = 12,
  parameter int CTX_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [OFS_W-1:0]       lk_ofs,
  input  logic [1:0]             lk_kind,
  input  logic [CTX_W-1:0]       lk_ctx,
  output logic                   lk_hit,
  output logic                   lk_miss,
  output logic [PPN_W-1:0]       lk_ppn,
  output logic [PPN_W+OFS_W-1:0] lk_paddr,
  output logic                   lk_fault,
  input  logic                   fl_en,
  input  logic [VPN_W-1:0]       fl_vpn,
  input  logic [CTX_W-1:0]       fl_ctx,
  input  logic [PPN_W-1:0]       fl_ppn,
  input  logic [2:0]             fl_perm,
  input  logic                   fl_pte_ok,
  input  logic                   iv_all,
  input  logic                   iv_ctx_en,
  input  logic [CTX_W-1:0]       iv_ctx
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   t_vpn  [ENTRIES];
  logic [CTX_W-1:0]   t_ctx  [ENTRIES];
  logic [PPN_W-1:0]   t_ppn  [ENTRIES];
  logic [2:0]         t_perm [ENTRIES];
  logic [IDX_W-1:0]   rr;

  logic [ENTRIES-1:0] hit_v, same_v;
  logic [PPN_W-1:0]   sel_ppn;
  logic [2:0]         sel_perm;
  logic [IDX_W-1:0]   free_idx, same_idx, dst;
  logic               any_free, any_same, fl_go, use_rr, allow;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_v[g]  = vld[g] && t_vpn[g] == lk_vpn && t_ctx[g] == lk_ctx;
    assign same_v[g] = vld[g] && t_vpn[g] == fl_vpn && t_ctx[g] == fl_ctx;
  end

  always_comb begin
    sel_ppn  = '0;
    sel_perm = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_v[i]) begin
        sel_ppn  = sel_ppn | t_ppn[i];
        sel_perm = sel_perm | t_perm[i];
      end
  end

  always_comb begin
    free_idx = '0;
    same_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i])   free_idx = IDX_W'(i);
      if (same_v[i]) same_idx = IDX_W'(i);
    end
  end

  assign any_free = ~&vld;
  assign any_same = |same_v;
  assign fl_go    = fl_en && fl_pte_ok && !iv_all && !iv_ctx_en;
  assign use_rr   = !any_same && !any_free;
  assign dst      = any_same ? same_idx : (any_free ? free_idx : rr);

  always_comb
    case (lk_kind)
      2'd0:    allow = sel_perm[0];
      2'd1:    allow = sel_perm[1];
      2'd2:    allow = sel_perm[2];
      default: allow = 1'b0;
    endcase

  assign lk_hit   = |hit_v;
  assign lk_miss  = ~lk_hit;
  assign lk_ppn   = sel_ppn;
  assign lk_paddr = lk_hit ? {sel_ppn, lk_ofs} : '0;
  assign lk_fault = lk_hit && !allow;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vld <= '0;
      rr  <= '0;
    end else if (iv_all) begin
      vld <= '0;
    end else if (iv_ctx_en) begin
      for (int i = 0; i < ENTRIES; i++)
        if (t_ctx[i] == iv_ctx) vld[i] <= 1'b0;
    end else if (fl_go) begin
      vld[dst] <= 1'b1;
      if (use_rr) rr <= (rr == LAST) ? '0 : rr + 1'b1;
    end

  always_ff @(posedge clk)
    if (fl_go) begin
      t_vpn[dst]  <= fl_vpn;
      t_ctx[dst]  <= fl_ctx;
      t_ppn[dst]  <= fl_ppn;
      t_perm[dst] <= fl_perm;
    end

  // R4 R8
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_v));

  // R9
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iv_all |=> vld == '0);

  // R5
  drop_bad_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_en && !fl_pte_ok && !iv_all && !iv_ctx_en) |=> $stable(vld));

  // R11
  inv_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_en && fl_pte_ok && (iv_all || iv_ctx_en)) |=> (vld & ~$past(vld)) == '0);

  // R3
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> !lk_fault);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    // R10
    ctx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iv_ctx_en && !iv_all && t_ctx[g] == iv_ctx) |=> !vld[g]);
  end
endmodule

// File: tb/tb_xlate_cache.sv
module tb_xlate_cache;
  localparam int CLK_P = 10;
  localparam int N = 4, VW = 20, PW = 20, OW = 12, CW = 4;

  logic clk = 0, rst_n = 0;
  logic [VW-1:0] lk_vpn = '0, fl_vpn = '0;
  logic [OW-1:0] lk_ofs = '0;
  logic [1:0] lk_kind = '0;
  logic [CW-1:0] lk_ctx = '0, fl_ctx = '0, iv_ctx = '0;
  logic lk_hit, lk_miss, lk_fault;
  logic [PW-1:0] lk_ppn, fl_ppn = '0;
  logic [PW+OW-1:0] lk_paddr;
  logic fl_en = 0, fl_pte_ok = 0, iv_all = 0, iv_ctx_en = 0;
  logic [2:0] fl_perm = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  xlate_cache #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW), .OFS_W(OW), .CTX_W(CW)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [PW-1:0] pp(input logic [VW-1:0] v, input logic [CW-1:0] c);
    return (v ^ 20'h5A3C1) + {16'd0, c} * 20'h111;
  endfunction

  task automatic fill(input logic [VW-1:0] v, input logic [CW-1:0] c, input logic [PW-1:0] p,
                      input logic [2:0] pm, input logic ok);
    @(negedge clk);
    fl_en = 1; fl_vpn = v; fl_ctx = c; fl_ppn = p; fl_perm = pm; fl_pte_ok = ok;
    @(negedge clk);
    fl_en = 0; fl_pte_ok = 0;
  endtask

  task automatic look(input string rq, input logic [VW-1:0] v, input logic [CW-1:0] c,
                      input logic eh, input logic [PW-1:0] ep);
    logic [PW+OW-1:0] ea;
    @(negedge clk);
    lk_vpn = v; lk_ctx = c; lk_ofs = OW'(v * 7 + 12'h3A5); lk_kind = 0;
    #1;
    ea = eh ? {ep, lk_ofs} : '0;
    n_chk++;
    if (lk_hit !== eh || lk_miss !== !eh || lk_ppn !== (eh ? ep : '0) || lk_paddr !== ea) begin
      n_bad++;
      $display("FAIL %s vpn=%h ctx=%0d: hit=%b ppn=%h pa=%h expected hit=%b ppn=%h pa=%h",
               rq, v, c, lk_hit, lk_ppn, lk_paddr, eh, eh ? ep : '0, ea);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    for (int v = 0; v < 4; v++) look("R12", VW'(v), 0, 0, 0);

    // R1 R2 basic fill and hit, R6 into free slots
    for (int v = 0; v < N; v++) fill(VW'(16 + v), 1, pp(VW'(16 + v), 1), 3'b111, 1);
    for (int v = 0; v < N; v++) look("R1", VW'(16 + v), 1, 1, pp(VW'(16 + v), 1));
    look("R1", 20'hFFFFF, 1, 0, 0);
    look("R4", 20'd16, 2, 0, 0);

    // R9 flush all
    @(negedge clk); iv_all = 1; @(negedge clk); iv_all = 0;
    for (int v = 0; v < N; v++) look("R9", VW'(16 + v), 1, 0, 0);

    // R5 fill without page valid ignored
    fill(20'h123, 1, 20'h77, 3'b111, 0);
    look("R5", 20'h123, 1, 0, 0);

    // R11 invalidate wins over fill
    @(negedge clk);
    fl_en = 1; fl_vpn = 20'h321; fl_ctx = 1; fl_ppn = 20'h9; fl_perm = 7; fl_pte_ok = 1; iv_ctx_en = 1; iv_ctx = 9;
    @(negedge clk); fl_en = 0; fl_pte_ok = 0; iv_ctx_en = 0;
    look("R11", 20'h321, 1, 0, 0);

    // R4 same VPN, different contexts: slots 0 A(c1) 1 A(c2) 2 C(c1) 3 D(c1)
    fill(20'hA, 1, pp(20'hA, 1), 7, 1);
    fill(20'hA, 2, pp(20'hA, 2), 7, 1);
    fill(20'hC, 1, pp(20'hC, 1), 7, 1);
    fill(20'hD, 1, pp(20'hD, 1), 7, 1);
    look("R4", 20'hA, 1, 1, pp(20'hA, 1));
    look("R4", 20'hA, 2, 1, pp(20'hA, 2));

    // R10 flush context 2 frees slot 1 only
    @(negedge clk); iv_ctx_en = 1; iv_ctx = 2; @(negedge clk); iv_ctx_en = 0;
    look("R10", 20'hA, 2, 0, 0);
    look("R10", 20'hA, 1, 1, pp(20'hA, 1));
    look("R10", 20'hC, 1, 1, pp(20'hC, 1));
    look("R10", 20'hD, 1, 1, pp(20'hD, 1));

    // R6 new key fills the hole at slot 1; nothing else lost
    fill(20'hE, 1, pp(20'hE, 1), 7, 1);
    look("R6", 20'hE, 1, 1, pp(20'hE, 1));
    look("R6", 20'hA, 1, 1, pp(20'hA, 1));
    look("R6", 20'hC, 1, 1, pp(20'hC, 1));
    look("R6", 20'hD, 1, 1, pp(20'hD, 1));

    // R7 full: victims are slot 0 then slot 1
    fill(20'hF, 1, pp(20'hF, 1), 7, 1);
    look("R7", 20'hA, 1, 0, 0);
    look("R7", 20'hF, 1, 1, pp(20'hF, 1));
    look("R7", 20'hE, 1, 1, pp(20'hE, 1));
    fill(20'h10F, 1, pp(20'h10F, 1), 7, 1);
    look("R7", 20'hE, 1, 0, 0);
    look("R7", 20'hF, 1, 1, pp(20'hF, 1));
    look("R7", 20'hC, 1, 1, pp(20'hC, 1));
    look("R7", 20'hD, 1, 1, pp(20'hD, 1));

    // R8 and R3: refill key F with every permission code, sweep kinds
    for (int p = 0; p < 8; p++) begin
      fill(20'hF, 1, PW'(p * 3 + 1), 3'(p), 1);
      for (int k = 0; k < 4; k++) begin
        logic ef;
        @(negedge clk);
        lk_vpn = 20'hF; lk_ctx = 1; lk_kind = 2'(k);
        #1;
        ef = (k == 3) ? 1'b1 : !p[k];
        n_chk++;
        if (lk_fault !== ef || lk_hit !== 1'b1) begin
          n_bad++;
          $display("FAIL R3 perm=%0d kind=%0d: fault=%b hit=%b expected fault=%b hit=1",
                   p, k, lk_fault, lk_hit, ef);
        end
      end
      look("R8", 20'hF, 1, 1, PW'(p * 3 + 1));
    end
    look("R8", 20'h10F, 1, 1, pp(20'h10F, 1));
    look("R8", 20'hC, 1, 1, pp(20'hC, 1));
    look("R8", 20'hD, 1, 1, pp(20'hD, 1));

    // R3 no fault on a miss with a forbidden kind
    @(negedge clk); lk_vpn = 20'h777; lk_ctx = 1; lk_kind = 3; #1;
    n_chk++;
    if (lk_fault !== 1'b0) begin
      n_bad++;
      $display("FAIL R3 miss: fault=%b expected 0", lk_fault);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule